// File: doc/BRIEF.md
# Memory-Attribute Register Access Router

This block owns the two 64-bit memory-attribute registers of a processor core: one used by the kernel privilege level (EL1) and one used by the hypervisor level (EL2). Each instruction-level request names one of the two registers and arrives with a read or write flag, the current exception level and a set of virtualization and trap controls. The router decides the outcome of the request. It can be undefined, trapped to EL2, redirected to a backing memory slot, or completed on one of the two registers. The register that completes an access need not be the register that the request named.

The decision is made in one combinational stage and then registered. One clock after a request is accepted, a single-cycle response reports the outcome. That response carries the read data, the undefined and trap flags with an exception class, or a memory request with a fixed slot offset and the write data. A parameter removes the hypervisor register entirely for cores built without EL2.

Top module: `attr_reg_router`

## Requirements
- R1: Any request made at exception level 0 (`req_el` = 0) is answered as undefined, for either register name and either direction.
- R2: At EL1 a request naming the hypervisor register (`req_name_hyp` = 1) traps when `ctl_nv[0]` is 1 and is undefined otherwise.
- R3: At EL1 a read naming the kernel register traps when `ctl_el2_en` and `ctl_vm_rd_trap` are both 1. A write naming the kernel register traps when `ctl_el2_en` and `ctl_vm_wr_trap` are both 1. The read bit has no effect on writes, and the write bit has no effect on reads.
- R4: At EL1 an access naming the kernel register takes the fine-grained trap when all of the following hold: `ctl_el2_en` is 1, `ctl_fg_present` is 1, either `ctl_el3_present` is 0 or `ctl_el3_fg_en` is 1, and the direction's own bit is 1 (`ctl_fg_rd_trap` for reads, `ctl_fg_wr_trap` for writes).
- R5: The checks for a kernel-register access at EL1 are applied in a fixed order: the virtual-memory trap, then the fine-grained trap, then the memory redirect, then the normal access. Any trap therefore wins over a redirect.
- R6: At EL1, when `ctl_nv` is 3'b111 and no trap applies, a kernel-register access becomes a memory request at offset 0x140. The response carries the direction in `rsp_mem_write` and, for a write, the write data in `rsp_mem_wdata`. The register itself is not read or written.
- R7: At EL2 a request naming the hypervisor register reaches the hypervisor register. A request naming the kernel register reaches the hypervisor register when `ctl_host` is 1 and the kernel register otherwise.
- R8: At EL3 each register name reaches its own register, and the request is never trapped or undefined.
- R9: Every trap reports exception class 0x18 on `rsp_ec`. `rsp_ec` is 0 in every other response.
- R10: With `EL2_IMPL` = 0 the hypervisor register reads as zero and ignores writes. Requests made at EL2, and EL1 requests naming the hypervisor register, are undefined. Traps and redirects that depend on EL2 never occur.
- R11: An undefined, trapped or redirected request leaves both registers unchanged. A completed write replaces all 64 bits of its target at once.
- R12: A request accepted on a clock edge is answered by `rsp_valid` high for exactly the next cycle. `rsp_rdata` holds the target's value from before the request only for a completed read, and is zero otherwise. After reset all outputs are zero and both registers hold `RST_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_name_hyp | input | 1 | 1 = request names the hypervisor register, 0 = kernel register |
| req_el | input | 2 | Current exception level 0..3 |
| req_wdata | input | DATA_W | Write data |
| ctl_nv | input | 3 | Nested-virtualization control bits |
| ctl_host | input | 1 | Host mode active at EL2 |
| ctl_el2_en | input | 1 | EL2 enabled in the current security state |
| ctl_vm_rd_trap | input | 1 | Virtual-memory read trap |
| ctl_vm_wr_trap | input | 1 | Virtual-memory write trap |
| ctl_fg_present | input | 1 | Fine-grained trap feature present |
| ctl_el3_present | input | 1 | EL3 implemented |
| ctl_el3_fg_en | input | 1 | EL3 enable for fine-grained traps |
| ctl_fg_rd_trap | input | 1 | Fine-grained read trap bit |
| ctl_fg_wr_trap | input | 1 | Fine-grained write trap bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | DATA_W | Read data of a completed read |
| rsp_undef | output | 1 | Request was undefined |
| rsp_trap | output | 1 | Request trapped to EL2 |
| rsp_ec | output | EC_W | Exception class of a trap |
| rsp_mem_req | output | 1 | Request redirected to memory |
| rsp_mem_write | output | 1 | Redirected request is a write |
| rsp_mem_off | output | OFF_W | Memory slot offset of a redirect |
| rsp_mem_wdata | output | DATA_W | Write data of a redirected write |

## Verification
Several corner cases have a likely failure mode. A read-trap bit applied to writes (or the reverse) would trap half of the EL1 accesses that should complete. If the priority is broken, an access with every trap and all nested bits set would come back as a memory request, not a trap. A redirected or trapped write that still reached the register would show up later as wrong data on an EL3 read. Host mode applied to the wrong name, or at the wrong level, returns the other register's contents. A second instance built without EL2 runs the same stimulus to show the zero-reading, write-ignoring hypervisor register. Random traffic covers all four levels and every control combination, and is checked against a bench model of both registers.

// File: rtl/attr_rt_pkg.sv
package attr_rt_pkg;

   typedef enum logic [2:0] {
      RT_UNDEF = 3'd0,
      RT_TRAP  = 3'd1,
      RT_MEM   = 3'd2,
      RT_KERN  = 3'd3,
      RT_HYP   = 3'd4
   } route_e;

   typedef struct packed {
      logic [2:0] nv;
      logic       host;
      logic       el2_en;
      logic       vm_rd;
      logic       vm_wr;
      logic       fg_present;
      logic       el3_present;
      logic       el3_fg_en;
      logic       fg_rd;
      logic       fg_wr;
   } ctl_t;

   localparam logic [1:0] LVL_USER = 2'd0;
   localparam logic [1:0] LVL_KERN = 2'd1;
   localparam logic [1:0] LVL_HYP  = 2'd2;
   localparam logic [1:0] LVL_MON  = 2'd3;

endpackage

// File: rtl/attr_rt_decode.sv
module attr_rt_decode
   import attr_rt_pkg::*;
#(
   parameter bit EL2_IMPL = 1'b1
) (
   input  logic [1:0] el,
   input  logic       name_hyp,
   input  logic       write,
   input  ctl_t       ctl,
   output route_e     route
);

   logic el2_on;
   logic vm_hit;
   logic fg_gate;
   logic fg_hit;
   logic nv_all;

   assign el2_on  = EL2_IMPL && ctl.el2_en;
   assign vm_hit  = el2_on && (write ? ctl.vm_wr : ctl.vm_rd);
   assign fg_gate = el2_on && ctl.fg_present && (!ctl.el3_present || ctl.el3_fg_en);
   assign fg_hit  = fg_gate && (write ? ctl.fg_wr : ctl.fg_rd);
   assign nv_all  = EL2_IMPL && (ctl.nv == 3'b111);

   always_comb begin
      route = RT_UNDEF;
      unique case (el)
         LVL_USER: route = RT_UNDEF;
         LVL_KERN: begin
            if (name_hyp) begin
               route = (EL2_IMPL && ctl.nv[0]) ? RT_TRAP : RT_UNDEF;
            end else if (vm_hit) begin
               route = RT_TRAP;
            end else if (fg_hit) begin
               route = RT_TRAP;
            end else if (nv_all) begin
               route = RT_MEM;
            end else begin
               route = RT_KERN;
            end
         end
         LVL_HYP: begin
            if (!EL2_IMPL) begin
               route = RT_UNDEF;
            end else if (name_hyp || ctl.host) begin
               route = RT_HYP;
            end else begin
               route = RT_KERN;
            end
         end
         LVL_MON: route = name_hyp ? RT_HYP : RT_KERN;
         default: route = RT_UNDEF;
      endcase
   end

endmodule

// File: rtl/attr_rt_regs.sv
module attr_rt_regs #(
   parameter int                DATA_W   = 64,
   parameter bit                EL2_IMPL = 1'b1,
   parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_k,
   input  logic              we_h,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] k_q,
   output logic [DATA_W-1:0] h_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q <= RST_VAL;
      end else if (we_k) begin
         k_q <= wdata;
      end
   end

   generate
      if (EL2_IMPL) begin : g_hyp
         logic [DATA_W-1:0] h_store;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               h_store <= RST_VAL;
            end else if (we_h) begin
               h_store <= wdata;
            end
         end
         assign h_q = h_store;
      end else begin : g_nohyp
         assign h_q = '0;
      end
   endgenerate

   // R11
   only_one_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_k && we_h));

endmodule

// File: rtl/attr_rt_resp.sv
module attr_rt_resp
   import attr_rt_pkg::*;
#(
   parameter int                DATA_W  = 64,
   parameter int                EC_W    = 6,
   parameter logic [EC_W-1:0]   TRAP_EC = 6'h18,
   parameter int                OFF_W   = 12,
   parameter logic [OFF_W-1:0]  MEM_OFF = 12'h140
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  route_e            route,
   input  logic              write,
   input  logic [DATA_W-1:0] k_val,
   input  logic [DATA_W-1:0] h_val,
   input  logic [DATA_W-1:0] wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_undef,
   output logic              rsp_trap,
   output logic [EC_W-1:0]   rsp_ec,
   output logic              rsp_mem_req,
   output logic              rsp_mem_write,
   output logic [OFF_W-1:0]  rsp_mem_off,
   output logic [DATA_W-1:0] rsp_mem_wdata
);

   logic [DATA_W-1:0] rd_next;
   logic              is_mem;
   logic              is_trap;

   assign is_mem  = acc && (route == RT_MEM);
   assign is_trap = acc && (route == RT_TRAP);

   always_comb begin
      rd_next = '0;
      if (acc && !write) begin
         if (route == RT_KERN) rd_next = k_val;
         else if (route == RT_HYP) rd_next = h_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_rdata     <= '0;
         rsp_undef     <= 1'b0;
         rsp_trap      <= 1'b0;
         rsp_ec        <= '0;
         rsp_mem_req   <= 1'b0;
         rsp_mem_write <= 1'b0;
         rsp_mem_off   <= '0;
         rsp_mem_wdata <= '0;
      end else begin
         rsp_valid     <= acc;
         rsp_rdata     <= rd_next;
         rsp_undef     <= acc && (route == RT_UNDEF);
         rsp_trap      <= is_trap;
         rsp_ec        <= is_trap ? TRAP_EC : '0;
         rsp_mem_req   <= is_mem;
         rsp_mem_write <= is_mem && write;
         rsp_mem_off   <= is_mem ? MEM_OFF : '0;
         rsp_mem_wdata <= (is_mem && write) ? wdata : '0;
      end
   end

   // R12
   outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_undef, rsp_trap, rsp_mem_req}));

   // R12
   no_flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_undef || rsp_trap || rsp_mem_req));

   // R9
   trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> (rsp_ec == TRAP_EC));

endmodule

// File: rtl/attr_reg_router.sv
module attr_reg_router
   import attr_rt_pkg::*;
#(
   parameter int                DATA_W   = 64,
   parameter int                EC_W     = 6,
   parameter logic [EC_W-1:0]   TRAP_EC  = 6'h18,
   parameter int                OFF_W    = 12,
   parameter logic [OFF_W-1:0]  MEM_OFF  = 12'h140,
   parameter bit                EL2_IMPL = 1'b1,
   parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_name_hyp,
   input  logic [1:0]        req_el,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [2:0]        ctl_nv,
   input  logic              ctl_host,
   input  logic              ctl_el2_en,
   input  logic              ctl_vm_rd_trap,
   input  logic              ctl_vm_wr_trap,
   input  logic              ctl_fg_present,
   input  logic              ctl_el3_present,
   input  logic              ctl_el3_fg_en,
   input  logic              ctl_fg_rd_trap,
   input  logic              ctl_fg_wr_trap,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_undef,
   output logic              rsp_trap,
   output logic [EC_W-1:0]   rsp_ec,
   output logic              rsp_mem_req,
   output logic              rsp_mem_write,
   output logic [OFF_W-1:0]  rsp_mem_off,
   output logic [DATA_W-1:0] rsp_mem_wdata
);

   localparam int EC_MAX  = (1 << EC_W) - 1;
   localparam int OFF_MAX = (1 << OFF_W) - 1;

   initial begin
      assert (DATA_W >= 8 && (DATA_W % 8) == 0)
         else $error("DATA_W must be a nonzero multiple of 8");
      assert (EC_W >= 1 && EC_W <= 16 && int'(TRAP_EC) <= EC_MAX)
         else $error("TRAP_EC does not fit in EC_W");
      assert (OFF_W >= 1 && OFF_W <= 30 && int'(MEM_OFF) <= OFF_MAX)
         else $error("MEM_OFF does not fit in OFF_W");
   end

   ctl_t              ctl;
   route_e            route;
   logic              we_k;
   logic              we_h;
   logic [DATA_W-1:0] k_q;
   logic [DATA_W-1:0] h_q;

   assign ctl = '{nv:          ctl_nv,
                  host:        ctl_host,
                  el2_en:      ctl_el2_en,
                  vm_rd:       ctl_vm_rd_trap,
                  vm_wr:       ctl_vm_wr_trap,
                  fg_present:  ctl_fg_present,
                  el3_present: ctl_el3_present,
                  el3_fg_en:   ctl_el3_fg_en,
                  fg_rd:       ctl_fg_rd_trap,
                  fg_wr:       ctl_fg_wr_trap};

   attr_rt_decode #(
      .EL2_IMPL (EL2_IMPL)
   ) u_decode (
      .el       (req_el),
      .name_hyp (req_name_hyp),
      .write    (req_write),
      .ctl      (ctl),
      .route    (route)
   );

   assign we_k = req_valid && req_write && (route == RT_KERN);
   assign we_h = req_valid && req_write && (route == RT_HYP);

   attr_rt_regs #(
      .DATA_W   (DATA_W),
      .EL2_IMPL (EL2_IMPL),
      .RST_VAL  (RST_VAL)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we_k  (we_k),
      .we_h  (we_h),
      .wdata (req_wdata),
      .k_q   (k_q),
      .h_q   (h_q)
   );

   attr_rt_resp #(
      .DATA_W  (DATA_W),
      .EC_W    (EC_W),
      .TRAP_EC (TRAP_EC),
      .OFF_W   (OFF_W),
      .MEM_OFF (MEM_OFF)
   ) u_resp (
      .clk           (clk),
      .rst_n         (rst_n),
      .acc           (req_valid),
      .route         (route),
      .write         (req_write),
      .k_val         (k_q),
      .h_val         (h_q),
      .wdata         (req_wdata),
      .rsp_valid     (rsp_valid),
      .rsp_rdata     (rsp_rdata),
      .rsp_undef     (rsp_undef),
      .rsp_trap      (rsp_trap),
      .rsp_ec        (rsp_ec),
      .rsp_mem_req   (rsp_mem_req),
      .rsp_mem_write (rsp_mem_write),
      .rsp_mem_off   (rsp_mem_off),
      .rsp_mem_wdata (rsp_mem_wdata)
   );

   // R1
   user_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_el == LVL_USER) |=> rsp_undef);

   // R8
   mon_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_el == LVL_MON) |=> (!rsp_trap && !rsp_undef && !rsp_mem_req));

   // R11
   regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (route == RT_UNDEF || route == RT_TRAP || route == RT_MEM))
      |=> ($stable(k_q) && $stable(h_q)));

   // R11
   full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_k |=> (k_q == $past(req_wdata)));

   // R12
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R12
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R6
   mem_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_mem_req |-> (rsp_mem_off == MEM_OFF));

endmodule

// File: tb/attr_reg_router_test.sv
module attr_reg_router_test;

   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_write = 1'b0;
   logic         req_name_hyp = 1'b0;
   logic [1:0]   req_el = 2'd0;
   logic [W-1:0] req_wdata = '0;
   logic [2:0]   ctl_nv = 3'd0;
   logic         ctl_host = 1'b0;
   logic         ctl_el2_en = 1'b0;
   logic         ctl_vm_rd_trap = 1'b0;
   logic         ctl_vm_wr_trap = 1'b0;
   logic         ctl_fg_present = 1'b0;
   logic         ctl_el3_present = 1'b0;
   logic         ctl_el3_fg_en = 1'b0;
   logic         ctl_fg_rd_trap = 1'b0;
   logic         ctl_fg_wr_trap = 1'b0;

   logic         o_valid   [2];
   logic [W-1:0] o_rdata   [2];
   logic         o_undef   [2];
   logic         o_trap    [2];
   logic [5:0]   o_ec      [2];
   logic         o_mreq    [2];
   logic         o_mwr     [2];
   logic [11:0]  o_moff    [2];
   logic [W-1:0] o_mwdata  [2];

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [W-1:0] kref [2];
   logic [W-1:0] href [2];

   always #10 clk = ~clk;

   attr_reg_router uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_name_hyp(req_name_hyp), .req_el(req_el), .req_wdata(req_wdata),
      .ctl_nv(ctl_nv), .ctl_host(ctl_host), .ctl_el2_en(ctl_el2_en),
      .ctl_vm_rd_trap(ctl_vm_rd_trap), .ctl_vm_wr_trap(ctl_vm_wr_trap),
      .ctl_fg_present(ctl_fg_present), .ctl_el3_present(ctl_el3_present),
      .ctl_el3_fg_en(ctl_el3_fg_en), .ctl_fg_rd_trap(ctl_fg_rd_trap),
      .ctl_fg_wr_trap(ctl_fg_wr_trap),
      .rsp_valid(o_valid[0]), .rsp_rdata(o_rdata[0]), .rsp_undef(o_undef[0]),
      .rsp_trap(o_trap[0]), .rsp_ec(o_ec[0]), .rsp_mem_req(o_mreq[0]),
      .rsp_mem_write(o_mwr[0]), .rsp_mem_off(o_moff[0]), .rsp_mem_wdata(o_mwdata[0])
   );

   attr_reg_router #(.EL2_IMPL(1'b0)) uut_n2 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_name_hyp(req_name_hyp), .req_el(req_el), .req_wdata(req_wdata),
      .ctl_nv(ctl_nv), .ctl_host(ctl_host), .ctl_el2_en(ctl_el2_en),
      .ctl_vm_rd_trap(ctl_vm_rd_trap), .ctl_vm_wr_trap(ctl_vm_wr_trap),
      .ctl_fg_present(ctl_fg_present), .ctl_el3_present(ctl_el3_present),
      .ctl_el3_fg_en(ctl_el3_fg_en), .ctl_fg_rd_trap(ctl_fg_rd_trap),
      .ctl_fg_wr_trap(ctl_fg_wr_trap),
      .rsp_valid(o_valid[1]), .rsp_rdata(o_rdata[1]), .rsp_undef(o_undef[1]),
      .rsp_trap(o_trap[1]), .rsp_ec(o_ec[1]), .rsp_mem_req(o_mreq[1]),
      .rsp_mem_write(o_mwr[1]), .rsp_mem_off(o_moff[1]), .rsp_mem_wdata(o_mwdata[1])
   );

   // outcome codes: 0 undefined, 1 trap, 2 memory, 3 kernel reg, 4 hyp reg
   function automatic int predict(input bit impl);
      bit el2_on, vm, fg;
      el2_on = impl && ctl_el2_en;
      vm = el2_on && (req_write ? ctl_vm_wr_trap : ctl_vm_rd_trap);
      fg = el2_on && ctl_fg_present && (!ctl_el3_present || ctl_el3_fg_en)
           && (req_write ? ctl_fg_wr_trap : ctl_fg_rd_trap);
      case (req_el)
         2'd0: return 0;
         2'd1: begin
            if (req_name_hyp) return (impl && ctl_nv[0]) ? 1 : 0;
            if (vm || fg) return 1;
            if (impl && ctl_nv == 3'b111) return 2;
            return 3;
         end
         2'd2: begin
            if (!impl) return 0;
            return (req_name_hyp || ctl_host) ? 4 : 3;
         end
         default: return req_name_hyp ? 4 : 3;
      endcase
   endfunction

   function automatic string tag_of(input bit impl);
      if (!impl && (req_el == 2'd2 || req_name_hyp)) return "R10";
      case (req_el)
         2'd0: return "R1";
         2'd1: begin
            if (req_name_hyp) return "R2";
            if (ctl_el2_en && (ctl_vm_rd_trap || ctl_vm_wr_trap)) return "R3";
            if (ctl_el2_en && ctl_fg_present) return "R4";
            if (ctl_nv == 3'b111) return "R6";
            return "R11";
         end
         2'd2: return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic logic [150:0] pack_out(input int i);
      return {o_valid[i], o_undef[i], o_trap[i], o_ec[i], o_mreq[i], o_mwr[i],
              o_moff[i], o_mwdata[i], o_rdata[i]};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [150:0] act,
                        input logic [150:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at a falling edge, let the rising edge accept, sample at the next falling edge
   task automatic do_req(input logic [1:0] el, input bit nh, input bit wr,
                         input logic [W-1:0] d, input string extra);
      int kind [2];
      logic [150:0] exp [2];
      req_valid = 1'b1; req_el = el; req_name_hyp = nh; req_write = wr; req_wdata = d;
      for (int i = 0; i < 2; i++) begin
         logic [W-1:0] rd;
         kind[i] = predict(i == 0);
         rd = '0;
         if (!wr && kind[i] == 3) rd = kref[i];
         if (!wr && kind[i] == 4) rd = href[i];
         exp[i] = {1'b1, kind[i] == 0, kind[i] == 1, (kind[i] == 1) ? 6'h18 : 6'h00,
                   kind[i] == 2, (kind[i] == 2) && wr, (kind[i] == 2) ? 12'h140 : 12'h000,
                   ((kind[i] == 2) && wr) ? d : {W{1'b0}}, rd};
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 2; i++) begin
         string t;
         t = (extra != "") ? extra : tag_of(i == 0);
         check(pack_out(i) === exp[i], t, pack_out(i), exp[i]);
         if (kind[i] == 1)
            check(o_ec[i] === 6'h18, "R9", {145'd0, o_ec[i]}, {145'd0, 6'h18});
         if (wr && kind[i] == 3) kref[i] = d;
         if (wr && kind[i] == 4 && i == 0) href[i] = d;
      end
   endtask

   task automatic idle_check();
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < 2; i++)
         check(pack_out(i) === '0, "R12", pack_out(i), '0);
   endtask

   task automatic clear_ctl();
      ctl_nv = 3'd0; ctl_host = 0; ctl_el2_en = 0; ctl_vm_rd_trap = 0;
      ctl_vm_wr_trap = 0; ctl_fg_present = 0; ctl_el3_present = 0;
      ctl_el3_fg_en = 0; ctl_fg_rd_trap = 0; ctl_fg_wr_trap = 0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL R12 watchdog expired actual=%0d expected<=150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pa, pb;
      void'($urandom(32'h00C0FFEE));
      for (int i = 0; i < 2; i++) begin kref[i] = '0; href[i] = '0; end
      pa = 64'hA5A5_0123_4567_89AB;
      pb = 64'h0F1E_2D3C_4B5A_6978;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      for (int i = 0; i < 2; i++)
         check(pack_out(i) === '0, "R12", pack_out(i), '0);

      // R8 each name reaches its own register at EL3
      do_req(2'd3, 0, 1, pa, "R8");
      do_req(2'd3, 1, 1, pb, "R8");
      do_req(2'd3, 0, 0, '0, "R8");
      do_req(2'd3, 1, 0, '0, "R8");
      idle_check();

      // R1 user level
      do_req(2'd0, 0, 0, '0, "R1");
      do_req(2'd0, 1, 1, 64'hFFFF, "R1");

      // R2 hyp name from EL1
      ctl_nv = 3'b001;
      do_req(2'd1, 1, 1, 64'h1, "R2");
      ctl_nv = 3'b110;
      do_req(2'd1, 1, 0, '0, "R2");
      clear_ctl();

      // R3 per-direction virtual-memory traps
      ctl_el2_en = 1; ctl_vm_rd_trap = 1;
      do_req(2'd1, 0, 0, '0, "R3");
      do_req(2'd1, 0, 1, 64'h1111_2222_3333_4444, "R3");
      ctl_el2_en = 0;
      do_req(2'd1, 0, 0, '0, "R3");
      clear_ctl();

      // R4 fine-grained gating by the EL3 enable
      ctl_el2_en = 1; ctl_fg_present = 1; ctl_el3_present = 1; ctl_fg_wr_trap = 1;
      do_req(2'd1, 0, 1, pa, "R4");
      ctl_el3_present = 0;
      do_req(2'd1, 0, 1, pb, "R4");
      do_req(2'd1, 0, 0, '0, "R4");
      clear_ctl();

      // R5 every trap and the redirect at once
      ctl_el2_en = 1; ctl_vm_wr_trap = 1; ctl_fg_present = 1; ctl_fg_wr_trap = 1;
      ctl_nv = 3'b111;
      do_req(2'd1, 0, 1, 64'hDEAD_BEEF_0000_0001, "R5");
      ctl_vm_wr_trap = 0;
      do_req(2'd1, 0, 1, 64'hDEAD_BEEF_0000_0002, "R5");
      clear_ctl();

      // R6 redirect, then R11 kernel register untouched
      ctl_nv = 3'b111; ctl_el2_en = 1;
      do_req(2'd1, 0, 1, 64'h5555_AAAA_5555_AAAA, "R6");
      do_req(2'd1, 0, 0, '0, "R6");
      clear_ctl();
      do_req(2'd3, 0, 0, '0, "R11");
      do_req(2'd3, 1, 0, '0, "R11");

      // R7 host mode at EL2
      ctl_host = 1;
      do_req(2'd2, 0, 1, 64'h7777_0000_7777_0000, "R7");
      do_req(2'd3, 1, 0, '0, "R7");
      ctl_host = 0;
      do_req(2'd2, 0, 0, '0, "R7");
      do_req(2'd2, 1, 0, '0, "R7");
      idle_check();

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [1:0] el;
         logic [W-1:0] d;
         {ctl_nv, ctl_host, ctl_el2_en, ctl_vm_rd_trap, ctl_vm_wr_trap} = 7'($urandom);
         {ctl_fg_present, ctl_el3_present, ctl_el3_fg_en, ctl_fg_rd_trap,
          ctl_fg_wr_trap} = 5'($urandom);
         el = 2'($urandom);
         d = {$urandom, $urandom};
         do_req(el, 1'($urandom), 1'($urandom), d, "");
         if (($urandom % 16) == 0) idle_check();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule